// File: doc/BRIEF.md
# UART Receive FIFO Request Generator

This block sits beside a UART receive FIFO and decides when the FIFO has data worth collecting. It compares the live FIFO word count against a programmable watermark. When the count rises above that level, it raises a receive-data-full flag. That flag is then steered to either a DMA request line or an interrupt line.

A watermark above zero can leave a short trailing burst stranded below the threshold. To prevent this, an idle timer counts character times during which the receive line stays quiet. After a programmable gap, the timer forces the flag as long as the FIFO is not empty.

A small register view exposes the configuration and the live count. A watermark register holds the threshold and reads back the current word count. A control register holds the idle-gap selector, the two routing enables and two self-clearing flush strobes. The deserializer, the FIFO storage and the DMA engine are outside this block. The block sees them only through the count, empty, character-tick and start-bit inputs.

Top module: `rx_fifo_req_gen`

## Requirements
- R1: After a synchronous reset the watermark, the idle selector and both enables are 0, and `rdrf`, `dma_req`, `irq`, `flush_tx` and `flush_rx` are all low.
- R2: One clock after `rx_count` is strictly greater than the programmed watermark, `rdrf` is high.
- R3: A count equal to the watermark does not raise `rdrf`. With watermark 1 and one word held, reading address 0 returns 0x01010000.
- R4: Address 0 reads the watermark at bits [16 +: WM_W] and the live count at bits [24 +: CNT_W]. Address 1 reads the idle selector at bits [12:10], DMA enable at bit 0 and receive interrupt enable at bit 1. All other bits read 0.
- R5: With idle selector n in 1..7, a FIFO that is not empty raises `rdrf` one clock after the 2^(n-1)-th `char_tick` pulse. It stays low after one pulse fewer.
- R6: A `start_bit` pulse restarts the idle count from zero.
- R7: The idle count is held at zero while `rx_empty` is high. Idle selector 0 disables the idle path entirely.
- R8: One clock after the count drops to the watermark or below, with no idle condition, `rdrf` is low.
- R9: `dma_req` follows `rdrf` when DMA enable is set. Otherwise `irq` follows `rdrf` when receive interrupt enable is set. The two are never high together.
- R10: Writing 1 to control bit 15 or bit 14 gives a single-clock pulse on `flush_tx` or `flush_rx`, respectively. Both bits read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_count | input | CNT_W | Live receive FIFO word count |
| rx_empty | input | 1 | Receive FIFO empty status |
| char_tick | input | 1 | One-cycle pulse per full idle character time |
| start_bit | input | 1 | One-cycle pulse on detection of a new start bit |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 watermark, 1 control |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| rdrf | output | 1 | Receive-data-full flag |
| dma_req | output | 1 | DMA request |
| irq | output | 1 | Receive interrupt request |
| flush_tx | output | 1 | Transmit FIFO flush pulse |
| flush_rx | output | 1 | Receive FIFO flush pulse |

## Verification
The bench builds the block with its default depth of 16. This gives a 4-bit watermark field and a 5-bit count, so the full range from watermark 0 to 15 and a completely full FIFO both fit in a short run. The idle counter is 7 bits wide, so even the longest 64-character gap (selector 7) takes only a few hundred clocks. The bench can therefore walk the idle gap at its shortest, middle and longest settings and check the tick exactly one short of firing at each.

// File: rtl/rxrq_pkg.sv
`timescale 1ns/1ps
package rxrq_pkg;

    // register bit placement
    localparam int WM_LSB    = 16;
    localparam int CNT_LSB   = 24;
    localparam int IDLE_LSB  = 10;
    localparam int TXFL_BIT  = 15;
    localparam int RXFL_BIT  = 14;
    localparam int DMAEN_BIT = 0;
    localparam int RIE_BIT   = 1;

    // idle timer sizing: selector 7 -> 64 characters
    localparam int IDLE_SW   = 3;
    localparam int IDLE_CW   = 7;

    typedef enum logic {
        SEL_WM   = 1'b0,
        SEL_CTRL = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic [IDLE_SW-1:0] idle_sel;
        logic               dma_en;
        logic               rx_ie;
    } ctrl_t;

    typedef struct packed {
        logic rdrf;
        logic dma_req;
        logic irq;
    } req_t;

    // number of idle character times selected by a nonzero selector
    function automatic logic [IDLE_CW-1:0] idle_target(input logic [IDLE_SW-1:0] sel);
        logic [IDLE_CW-1:0] t;
        if (sel == '0) t = '0;
        else           t = IDLE_CW'(1) << (sel - IDLE_SW'(1));
        return t;
    endfunction

endpackage

// File: rtl/rxrq_regs.sv
`timescale 1ns/1ps
module rxrq_regs
    import rxrq_pkg::*;
#(
    parameter int WM_W  = 4,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic             addr,
    input  logic [31:0]      wdata,
    input  logic [CNT_W-1:0] count,
    output logic [31:0]      rdata,
    output logic [WM_W-1:0]  wm_o,
    output ctrl_t            ctrl_o,
    output logic             flush_tx_o,
    output logic             flush_rx_o
);

    logic [WM_W-1:0] wm_q;
    ctrl_t           ctrl_q;
    logic            ftx_q, frx_q;
    logic            wr_wm, wr_ctrl;

    assign wr_wm   = wr && (reg_sel_e'(addr) == SEL_WM);
    assign wr_ctrl = wr && (reg_sel_e'(addr) == SEL_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            wm_q   <= '0;
            ctrl_q <= '0;
            ftx_q  <= 1'b0;
            frx_q  <= 1'b0;
        end else begin
            ftx_q <= wr_ctrl && wdata[TXFL_BIT];
            frx_q <= wr_ctrl && wdata[RXFL_BIT];
            if (wr_wm)
                wm_q <= wdata[WM_LSB +: WM_W];
            if (wr_ctrl) begin
                ctrl_q.idle_sel <= wdata[IDLE_LSB +: IDLE_SW];
                ctrl_q.dma_en   <= wdata[DMAEN_BIT];
                ctrl_q.rx_ie    <= wdata[RIE_BIT];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (reg_sel_e'(addr) == SEL_WM) begin
            rdata[WM_LSB +: WM_W]   = wm_q;
            rdata[CNT_LSB +: CNT_W] = count;
        end else begin
            rdata[IDLE_LSB +: IDLE_SW] = ctrl_q.idle_sel;
            rdata[DMAEN_BIT]           = ctrl_q.dma_en;
            rdata[RIE_BIT]             = ctrl_q.rx_ie;
        end
    end

    assign wm_o       = wm_q;
    assign ctrl_o     = ctrl_q;
    assign flush_tx_o = ftx_q;
    assign flush_rx_o = frx_q;

    // R10
    flush_rx_src_chk: assert property (@(posedge clk) disable iff (rst)
        frx_q |-> $past(wr && addr && wdata[RXFL_BIT]));

    // R10
    flush_tx_src_chk: assert property (@(posedge clk) disable iff (rst)
        ftx_q |-> $past(wr && addr && wdata[TXFL_BIT]));

endmodule

// File: rtl/rxrq_idle.sv
`timescale 1ns/1ps
module rxrq_idle
    import rxrq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [IDLE_SW-1:0] sel,
    input  logic               char_tick,
    input  logic               start_bit,
    input  logic               fifo_empty,
    output logic               idle_hit_o
);

    logic [IDLE_CW-1:0] cnt_q;
    logic [IDLE_CW-1:0] target;
    logic               enabled;

    assign target  = idle_target(sel);
    assign enabled = (sel != '0);

    always_ff @(posedge clk) begin
        if (rst || start_bit || fifo_empty || !enabled)
            cnt_q <= '0;
        else if (char_tick && (cnt_q < target))
            cnt_q <= cnt_q + IDLE_CW'(1);
    end

    assign idle_hit_o = enabled && !fifo_empty && (cnt_q >= target);

    // R6
    idle_restart_chk: assert property (@(posedge clk) disable iff (rst)
        start_bit |=> (cnt_q == '0));

    // R7
    idle_empty_hold_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_empty |=> (cnt_q == '0));

    // R5
    idle_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!char_tick && !start_bit && !fifo_empty && enabled && $stable(sel)) |=> $stable(cnt_q));

endmodule

// File: rtl/rxrq_req.sv
`timescale 1ns/1ps
module rxrq_req
    import rxrq_pkg::*;
#(
    parameter int WM_W  = 4,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] count,
    input  logic [WM_W-1:0]  wm,
    input  logic             idle_hit,
    input  ctrl_t            ctrl,
    output req_t             req_o
);

    logic thr_hit;
    logic flag_d;
    req_t req_q;

    assign thr_hit = count > CNT_W'(wm);
    assign flag_d  = thr_hit || idle_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else begin
            req_q.rdrf    <= flag_d;
            req_q.dma_req <= flag_d && ctrl.dma_en;
            req_q.irq     <= flag_d && !ctrl.dma_en && ctrl.rx_ie;
        end
    end

    assign req_o = req_q;

    // R2
    thr_raise_chk: assert property (@(posedge clk) disable iff (rst)
        thr_hit |=> req_q.rdrf);

    // R8
    flag_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (!thr_hit && !idle_hit) |=> !req_q.rdrf);

    // R9
    route_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_q.dma_req && req_q.irq));

    // R9
    route_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (req_q.dma_req || req_q.irq) |-> req_q.rdrf);

endmodule

// File: rtl/rx_fifo_req_gen.sv
`timescale 1ns/1ps
module rx_fifo_req_gen
    import rxrq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int WM_W  = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             rx_empty,
    input  logic             char_tick,
    input  logic             start_bit,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             rdrf,
    output logic             dma_req,
    output logic             irq,
    output logic             flush_tx,
    output logic             flush_rx
);

    logic [WM_W-1:0] wm;
    ctrl_t           ctrl;
    logic            idle_hit;
    req_t            req;

    rxrq_regs #(.WM_W(WM_W), .CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr         (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .count      (rx_count),
        .rdata      (reg_rdata),
        .wm_o       (wm),
        .ctrl_o     (ctrl),
        .flush_tx_o (flush_tx),
        .flush_rx_o (flush_rx)
    );

    rxrq_idle u_idle (
        .clk        (clk),
        .rst        (rst),
        .sel        (ctrl.idle_sel),
        .char_tick  (char_tick),
        .start_bit  (start_bit),
        .fifo_empty (rx_empty),
        .idle_hit_o (idle_hit)
    );

    rxrq_req #(.WM_W(WM_W), .CNT_W(CNT_W)) u_req (
        .clk      (clk),
        .rst      (rst),
        .count    (rx_count),
        .wm       (wm),
        .idle_hit (idle_hit),
        .ctrl     (ctrl),
        .req_o    (req)
    );

    assign rdrf    = req.rdrf;
    assign dma_req = req.dma_req;
    assign irq     = req.irq;

    // R7
    empty_no_idle_chk: assert property (@(posedge clk) disable iff (rst)
        rx_empty |-> !idle_hit);

endmodule

// File: tb/sim_rx_fifo_req_gen.sv
`timescale 1ns/1ps
module sim_rx_fifo_req_gen;

    localparam int DEPTH = 16;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [CNT_W-1:0] rx_count = '0;
    logic             rx_empty = 1'b1;
    logic             char_tick = 1'b0;
    logic             start_bit = 1'b0;
    logic             reg_wr = 1'b0;
    logic             reg_addr = 1'b0;
    logic [31:0]      reg_wdata = '0;
    logic [31:0]      reg_rdata;
    logic             rdrf, dma_req, irq, flush_tx, flush_rx;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;  // 200 MHz

    rx_fifo_req_gen #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .rx_count(rx_count), .rx_empty(rx_empty),
        .char_tick(char_tick), .start_bit(start_bit),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .rdrf(rdrf), .dma_req(dma_req), .irq(irq),
        .flush_tx(flush_tx), .flush_rx(flush_rx)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wreg(input logic a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    function automatic logic [31:0] ctrl_word(input int idle, input bit dma, input bit rie);
        return (32'(idle) << 10) | (32'(rie) << 1) | 32'(dma);
    endfunction

    task automatic set_fifo(input int c);
        rx_count = CNT_W'(c);
        rx_empty = (c == 0);
    endtask

    task automatic ticks(input int k);
        for (int i = 0; i < k; i++) begin
            char_tick = 1'b1;
            @(negedge clk);
            char_tick = 1'b0;
        end
    endtask

    task automatic restart;
        start_bit = 1'b1;
        @(negedge clk);
        start_bit = 1'b0;
    endtask

    task automatic t_reset;
        reg_addr = 1'b0;
        #0;
        check("R1 wm reg", reg_rdata, 32'h0);
        reg_addr = 1'b1;
        #1;
        check("R1 ctrl reg", reg_rdata, 32'h0);
        check("R1 outputs", {27'b0, rdrf, dma_req, irq, flush_tx, flush_rx}, 32'h0);
    endtask

    task automatic t_threshold;
        wreg(1'b0, 32'd3 << 16);
        set_fifo(3); step(1);
        check("R3 count==wm", {31'b0, rdrf}, 0);
        set_fifo(4); step(1);
        check("R2 count>wm", {31'b0, rdrf}, 1);
        wreg(1'b0, 32'd0);
        set_fifo(1); step(1);
        check("R2 wm0 one word", {31'b0, rdrf}, 1);
        wreg(1'b0, 32'd15 << 16);
        set_fifo(16); step(1);
        check("R2 full fifo wm15", {31'b0, rdrf}, 1);
        set_fifo(15); step(1);
        check("R8 drop to wm15", {31'b0, rdrf}, 0);
    endtask

    task automatic t_readback;
        wreg(1'b0, 32'd1 << 16);
        set_fifo(1);
        reg_addr = 1'b0;
        step(1);
        check("R3 readback", reg_rdata, 32'h0101_0000);
        check("R3 no flag", {31'b0, rdrf}, 0);
        set_fifo(16); #1;
        check("R4 count field", reg_rdata, 32'h1001_0000);
        wreg(1'b1, ctrl_word(5, 1, 1) | 32'hFFFF_C000);
        reg_addr = 1'b1; #1;
        check("R4 ctrl readback", reg_rdata, ctrl_word(5, 1, 1));
        wreg(1'b1, 0);
    endtask

    task automatic t_deassert;
        wreg(1'b0, 32'd2 << 16);
        set_fifo(5); step(1);
        check("R2 raise", {31'b0, rdrf}, 1);
        set_fifo(2); step(1);
        check("R8 drop at wm", {31'b0, rdrf}, 0);
    endtask

    task automatic t_idle_gap(input int sel);
        int tgt = 1 << (sel - 1);
        wreg(1'b0, 32'd8 << 16);
        wreg(1'b1, ctrl_word(sel, 0, 0));
        set_fifo(2);
        restart;
        ticks(tgt - 1); step(1);
        check($sformatf("R5 sel%0d one short", sel), {31'b0, rdrf}, 0);
        ticks(1); step(1);
        check($sformatf("R5 sel%0d fires", sel), {31'b0, rdrf}, 1);
        set_fifo(0); step(1);
        check("R7 empty clears idle", {31'b0, rdrf}, 0);
    endtask

    task automatic t_restart;
        wreg(1'b0, 32'd8 << 16);
        wreg(1'b1, ctrl_word(3, 0, 0));
        set_fifo(3);
        restart;
        ticks(3);
        restart;
        ticks(3); step(1);
        check("R6 restart holds", {31'b0, rdrf}, 0);
        ticks(1); step(1);
        check("R6 fires after restart", {31'b0, rdrf}, 1);
        set_fifo(0); step(1);
    endtask

    task automatic t_empty_disable;
        wreg(1'b0, 32'd8 << 16);
        wreg(1'b1, ctrl_word(2, 0, 0));
        set_fifo(0);
        ticks(4);
        set_fifo(1); step(1);
        check("R7 empty held count", {31'b0, rdrf}, 0);
        ticks(2); step(1);
        check("R7 fresh count fires", {31'b0, rdrf}, 1);
        wreg(1'b1, ctrl_word(0, 0, 0));
        restart;
        ticks(80); step(1);
        check("R7 selector 0 disables", {31'b0, rdrf}, 0);
        set_fifo(0);
    endtask

    task automatic t_routing;
        wreg(1'b0, 32'd2 << 16);
        set_fifo(5);
        wreg(1'b1, ctrl_word(0, 1, 1)); step(1);
        check("R9 dma route", {29'b0, rdrf, dma_req, irq}, 32'b110);
        wreg(1'b1, ctrl_word(0, 0, 1)); step(1);
        check("R9 irq route", {29'b0, rdrf, dma_req, irq}, 32'b101);
        wreg(1'b1, ctrl_word(0, 0, 0)); step(1);
        check("R9 none routed", {29'b0, rdrf, dma_req, irq}, 32'b100);
        set_fifo(0); step(1);
    endtask

    task automatic t_flush;
        wreg(1'b1, 32'h0000_4000);
        check("R10 rx pulse", {30'b0, flush_tx, flush_rx}, 32'b01);
        step(1);
        check("R10 rx self clear", {30'b0, flush_tx, flush_rx}, 32'b00);
        wreg(1'b1, 32'h0000_8000);
        check("R10 tx pulse", {30'b0, flush_tx, flush_rx}, 32'b10);
        reg_addr = 1'b1;
        step(1);
        check("R10 tx self clear", {30'b0, flush_tx, flush_rx}, 32'b00);
        check("R10 bits read 0", reg_rdata, 32'h0);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        step(3);
        rst = 1'b0;
        t_reset;
        t_threshold;
        t_readback;
        t_deassert;
        t_idle_gap(1);
        t_idle_gap(3);
        t_idle_gap(7);
        t_restart;
        t_empty_disable;
        t_routing;
        t_flush;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule